// File: doc/BRIEF.md
# Packed-Decimal Digit Shifter with Rounding

This block moves the digits of a packed-decimal field toward the more significant end or toward the less significant end. The field is up to sixteen bytes long and the result is written back in the same byte layout. A signed six-bit count selects the direction and the distance. On a move toward the less significant end, a supplied rounding digit is added to the most significant digit that is discarded, and a carry out of that addition is added to the digits that remain. The sign nibble keeps its position. The block reports a two-bit condition code and flags a field that holds an illegal digit or sign code.

The field is right-justified in the operand bus. Byte 0 is the least significant byte: its low nibble holds the sign and its high nibble holds digit 0. Digit i sits in nibble i+1. A field of B bytes holds 2B-1 digits. The caller pulses `start_i` with the operands present and reads the result when `done_o` is high. The result then stays on the outputs until the next operation finishes.

Top module: `dec_shift_round`

## Requirements
- R1: The count `shamt_i` is read as a two's-complement six-bit number. Values 1 to 31 move digits toward the more significant end by that many places. Values 32 to 63 move them toward the less significant end by 64 minus the value, which gives 32 down to 1 places.
- R2: On a move toward the more significant end, digit i goes to position i+n. Vacated low positions become 0. Digits that would move to a position at or above the field's digit count are dropped.
- R3: When a move toward the more significant end drops any nonzero digit, the condition code is 3 (overflow). The truncated result is still written.
- R4: On a move toward the less significant end, digit i+n goes to position i and vacated high positions become 0. A count of 32 clears every digit of a full-length field.
- R5: Rounding applies only to moves toward the less significant end. The rounding digit (0 to 15, used as given) is added to the most significant discarded digit, which is 0 when that position lies outside the field. A sum of 10 or more adds 1 to the retained value. The rounding digit has no effect on moves toward the more significant end.
- R6: For a nonzero count, the sign nibble is rewritten as 0xC for plus or 0xD for minus. Input codes 0xB and 0xD are minus; 0xA, 0xC, 0xE and 0xF are plus. A result whose digits are all zero always gets 0xC.
- R7: Without overflow, the condition code is 0 when all result digits are zero, 1 for a negative result and 2 for a positive result.
- R8: A count of 0 returns the operand unchanged, including its sign code. Only the condition code is computed.
- R9: `len_i` holds the byte count minus one. The field covers bytes 0 to `len_i`. Bytes above the field are returned unchanged.
- R10: A digit above 9 inside the field, or a sign code below 0xA, sets `bad_o`. In that case the operand is returned unchanged and the condition code is 0.
- R11: `done_o` is high for exactly one cycle, 1+IN_REG cycles after the cycle in which `start_i` is sampled. `result_o`, `cc_o` and `bad_o` hold their values while `done_o` is low.
- R12: During reset, `done_o`, `result_o`, `cc_o` and `bad_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation on the present operands |
| len_i | input | $clog2(MAX_BYTES) | Field length in bytes, minus one |
| opd_i | input | 8*MAX_BYTES | Packed-decimal operand, byte 0 least significant |
| shamt_i | input | 6 | Signed digit count |
| rnd_i | input | 4 | Rounding digit |
| result_o | output | 8*MAX_BYTES | Shifted operand |
| cc_o | output | 2 | Condition code |
| bad_o | output | 1 | Illegal digit or sign seen |
| done_o | output | 1 | Result valid, one-cycle pulse |

## Verification
The bench builds the block with MAX_BYTES=16 and IN_REG=1. A 31-digit field makes every one of the 64 count codes meaningful. It also reaches the two extreme cases: a move of 31 places toward the more significant end, and a move of 32 places toward the less significant end that clears all digits. IN_REG=1 selects the registered-input variant, so the checks run against the two-cycle latency. Random field lengths from 1 to 16 bytes, with varying runs of leading zeros, cover overflow and non-overflow moves, carries that ripple through runs of nines, and preservation of the bytes above the field.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   localparam logic [1:0] CC_ZERO = 2'd0;
   localparam logic [1:0] CC_NEG  = 2'd1;
   localparam logic [1:0] CC_POS  = 2'd2;
   localparam logic [1:0] CC_OVF  = 2'd3;

   localparam logic [3:0] SGN_PLUS  = 4'hC;
   localparam logic [3:0] SGN_MINUS = 4'hD;

   function automatic logic sign_is_neg(input logic [3:0] s);
      return (s == 4'hB) || (s == 4'hD);
   endfunction

   function automatic logic sign_is_legal(input logic [3:0] s);
      return s >= 4'hA;
   endfunction

endpackage

// File: rtl/dsr_unpack.sv
module dsr_unpack
   import dsr_pkg::*;
#(
   parameter int MAX_BYTES = 16,
   parameter int LEN_W     = $clog2(MAX_BYTES),
   parameter int NDIG      = 2*MAX_BYTES-1,
   parameter int DW        = $clog2(NDIG+2)
) (
   input  logic [8*MAX_BYTES-1:0] opd_i,
   input  logic [LEN_W-1:0]       len_i,
   output logic [4*NDIG-1:0]      dig_o,
   output logic [DW-1:0]          ndig_o,
   output logic                   neg_o,
   output logic                   legal_o
);

   logic [NDIG-1:0] in_fld;
   logic [NDIG-1:0] bad_dig;

   // digit count of the field is 2*bytes-1 = 2*len+1
   assign ndig_o = DW'({len_i, 1'b1});

   genvar g;
   generate
      for (g = 0; g < NDIG; g++) begin : g_dig
         logic [3:0] nib;
         assign nib                = opd_i[4*g+4 +: 4];
         assign in_fld[g]          = (DW'(g) < ndig_o);
         assign dig_o[4*g +: 4]    = in_fld[g] ? nib : 4'h0;
         assign bad_dig[g]         = in_fld[g] && (nib > 4'd9);
      end
   endgenerate

   assign neg_o   = sign_is_neg(opd_i[3:0]);
   assign legal_o = sign_is_legal(opd_i[3:0]) && !(|bad_dig);

endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter #(
   parameter int NDIG = 31,
   parameter int DW   = 6
) (
   input  logic [4*NDIG-1:0] dig_i,
   input  logic [DW-1:0]     ndig_i,
   input  logic [5:0]        shamt_i,
   input  logic [3:0]        rnd_i,
   output logic [4*NDIG-1:0] dig_o,
   output logic              left_o,
   output logic              right_o,
   output logic              ovf_o,
   output logic              carry_o
);

   logic [3:0] din  [NDIG];
   logic [3:0] dout [NDIG];

   genvar g;
   generate
      for (g = 0; g < NDIG; g++) begin : g_map
         assign din[g]          = dig_i[4*g +: 4];
         assign dig_o[4*g +: 4] = dout[g];
      end
   endgenerate

   int         nd;
   int         lamt;
   int         ramt;
   logic [3:0] dropped;
   logic [4:0] rsum;
   logic       cy;

   always_comb begin
      nd      = int'(ndig_i);
      lamt    = int'(shamt_i[4:0]);
      ramt    = 64 - int'(shamt_i);
      left_o  = (shamt_i != 6'd0) && !shamt_i[5];
      right_o = shamt_i[5];
      ovf_o   = 1'b0;
      carry_o = 1'b0;
      dropped = 4'h0;
      rsum    = 5'd0;
      cy      = 1'b0;
      for (int i = 0; i < NDIG; i++) dout[i] = 4'h0;

      if (left_o) begin
         for (int i = 0; i < NDIG; i++) begin
            if (i >= lamt && i < nd) dout[i] = din[i-lamt];
            if ((i + lamt >= nd) && (din[i] != 4'h0)) ovf_o = 1'b1;
         end
      end else if (right_o) begin
         for (int i = 0; i < NDIG; i++) begin
            if (i + ramt < NDIG) dout[i] = din[i+ramt];
         end
         if (ramt - 1 < NDIG) dropped = din[ramt-1];
         rsum    = {1'b0, dropped} + {1'b0, rnd_i};
         carry_o = (rsum >= 5'd10);
         cy      = carry_o;
         // ripple the rounding carry through retained digits
         for (int i = 0; i < NDIG; i++) begin
            if (cy) begin
               if (dout[i] == 4'd9) dout[i] = 4'd0;
               else begin
                  dout[i] = dout[i] + 4'd1;
                  cy      = 1'b0;
               end
            end
         end
      end else begin
         for (int i = 0; i < NDIG; i++) dout[i] = din[i];
      end
   end

endmodule

// File: rtl/dsr_pack.sv
module dsr_pack
   import dsr_pkg::*;
#(
   parameter int MAX_BYTES = 16,
   parameter int NDIG      = 2*MAX_BYTES-1,
   parameter int DW        = $clog2(NDIG+2)
) (
   input  logic [8*MAX_BYTES-1:0] opd_i,
   input  logic [4*NDIG-1:0]      dig_i,
   input  logic [DW-1:0]          ndig_i,
   input  logic                   neg_i,
   input  logic                   legal_i,
   input  logic                   keep_i,
   input  logic                   ovf_i,
   output logic [8*MAX_BYTES-1:0] res_o,
   output logic [1:0]             cc_o
);

   logic all_zero;
   assign all_zero = (dig_i == '0);

   always_comb begin
      res_o = opd_i;
      if (legal_i && !keep_i) begin
         for (int i = 0; i < NDIG; i++) begin
            if (i < int'(ndig_i)) res_o[4*i+4 +: 4] = dig_i[4*i +: 4];
         end
         res_o[3:0] = (neg_i && !all_zero) ? SGN_MINUS : SGN_PLUS;
      end
   end

   always_comb begin
      if (!legal_i)     cc_o = CC_ZERO;
      else if (ovf_i)   cc_o = CC_OVF;
      else if (all_zero) cc_o = CC_ZERO;
      else if (neg_i)   cc_o = CC_NEG;
      else              cc_o = CC_POS;
   end

endmodule

// File: rtl/dec_shift_round.sv
module dec_shift_round
   import dsr_pkg::*;
#(
   parameter int MAX_BYTES = 16,
   parameter bit IN_REG    = 1'b0,
   parameter int LEN_W     = $clog2(MAX_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start_i,
   input  logic [LEN_W-1:0]       len_i,
   input  logic [8*MAX_BYTES-1:0] opd_i,
   input  logic [5:0]             shamt_i,
   input  logic [3:0]             rnd_i,
   output logic [8*MAX_BYTES-1:0] result_o,
   output logic [1:0]             cc_o,
   output logic                   bad_o,
   output logic                   done_o
);

   localparam int W    = 8*MAX_BYTES;
   localparam int NDIG = 2*MAX_BYTES-1;
   localparam int DW   = $clog2(NDIG+2);

   initial begin
      assert (MAX_BYTES >= 2 && MAX_BYTES <= 16 && (MAX_BYTES & (MAX_BYTES-1)) == 0)
         else $error("MAX_BYTES must be a power of two from 2 to 16");
   end

   logic             go;
   logic [W-1:0]     opd_s;
   logic [LEN_W-1:0] len_s;
   logic [5:0]       sh_s;
   logic [3:0]       rnd_s;

   generate
      if (IN_REG) begin : g_inreg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               go    <= 1'b0;
               opd_s <= '0;
               len_s <= '0;
               sh_s  <= '0;
               rnd_s <= '0;
            end else begin
               go <= start_i;
               if (start_i) begin
                  opd_s <= opd_i;
                  len_s <= len_i;
                  sh_s  <= shamt_i;
                  rnd_s <= rnd_i;
               end
            end
         end
      end else begin : g_direct
         assign go    = start_i;
         assign opd_s = opd_i;
         assign len_s = len_i;
         assign sh_s  = shamt_i;
         assign rnd_s = rnd_i;
      end
   endgenerate

   logic [4*NDIG-1:0] up_dig;
   logic [DW-1:0]     up_nd;
   logic              up_neg;
   logic              up_legal;

   dsr_unpack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .NDIG(NDIG), .DW(DW)) u_unpack (
      .opd_i  (opd_s),
      .len_i  (len_s),
      .dig_o  (up_dig),
      .ndig_o (up_nd),
      .neg_o  (up_neg),
      .legal_o(up_legal)
   );

   logic [4*NDIG-1:0] sh_dig;
   logic              sh_left;
   logic              sh_right;
   logic              sh_ovf;
   logic              sh_carry;

   dsr_shifter #(.NDIG(NDIG), .DW(DW)) u_shift (
      .dig_i  (up_dig),
      .ndig_i (up_nd),
      .shamt_i(sh_s),
      .rnd_i  (rnd_s),
      .dig_o  (sh_dig),
      .left_o (sh_left),
      .right_o(sh_right),
      .ovf_o  (sh_ovf),
      .carry_o(sh_carry)
   );

   logic [W-1:0] pk_res;
   logic [1:0]   pk_cc;

   dsr_pack #(.MAX_BYTES(MAX_BYTES), .NDIG(NDIG), .DW(DW)) u_pack (
      .opd_i  (opd_s),
      .dig_i  (sh_dig),
      .ndig_i (up_nd),
      .neg_i  (up_neg),
      .legal_i(up_legal),
      .keep_i (sh_s == 6'd0),
      .ovf_i  (sh_ovf),
      .res_o  (pk_res),
      .cc_o   (pk_cc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         cc_o     <= CC_ZERO;
         bad_o    <= 1'b0;
         done_o   <= 1'b0;
      end else begin
         done_o <= go;
         if (go) begin
            result_o <= pk_res;
            cc_o     <= pk_cc;
            bad_o    <= !up_legal;
         end
      end
   end

   // R11
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(cc_o) && $stable(bad_o)));

   // R3
   ovf_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_ovf |-> sh_left);

   // R5
   carry_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_carry |-> sh_right);

   // R10
   bad_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && bad_o) |-> (cc_o == CC_ZERO));

   // R7
   neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !bad_o && cc_o == CC_NEG) |-> (result_o[3:0] == 4'hB || result_o[3:0] == 4'hD));

endmodule

// File: tb/dec_shift_round_test.sv
`timescale 1ns/1ps
module dec_shift_round_test;

   localparam int MB  = 16;
   localparam bit INR = 1'b1;
   localparam int LW  = $clog2(MB);
   localparam int W   = 8*MB;
   localparam int LAT = 1 + int'(INR);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [LW-1:0] len_i = '0;
   logic [W-1:0]  opd_i = '0;
   logic [5:0]    shamt_i = '0;
   logic [3:0]    rnd_i = '0;
   logic [W-1:0]  result_o;
   logic [1:0]    cc_o;
   logic          bad_o;
   logic          done_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dec_shift_round #(.MAX_BYTES(MB), .IN_REG(INR)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .opd_i(opd_i),
      .shamt_i(shamt_i), .rnd_i(rnd_i), .result_o(result_o), .cc_o(cc_o),
      .bad_o(bad_o), .done_o(done_o)
   );

   task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic model(input logic [W-1:0] opd, input int len, input logic [5:0] sh, input logic [3:0] rnd,
                        output logic [W-1:0] r, output logic [1:0] c, output logic b);
      int d[32];
      int e[32];
      int nd, n, rd, k;
      logic neg, ov, allz;
      logic [3:0] s;
      nd = 2*len + 1;
      s  = opd[3:0];
      b  = (s < 4'hA);
      for (int i = 0; i < 32; i++) begin d[i] = 0; e[i] = 0; end
      for (int i = 0; i < nd; i++) begin
         d[i] = int'(opd[4*i+4 +: 4]);
         if (d[i] > 9) b = 1'b1;
      end
      neg = (s == 4'hB) || (s == 4'hD);
      r   = opd;
      ov  = 1'b0;
      c   = 2'd0;
      if (!b) begin
         if (sh == 6'd0) begin
            for (int i = 0; i < 32; i++) e[i] = d[i];
         end else if (sh < 6'd32) begin
            n = int'(sh);
            for (int i = 0; i < nd; i++) begin
               if (d[i] != 0) begin
                  if (i + n >= nd) ov = 1'b1;
                  else e[i+n] = d[i];
               end
            end
         end else begin
            n = 64 - int'(sh);
            for (int i = 0; i < nd; i++) if (i >= n) e[i-n] = d[i];
            rd = (n - 1 < nd) ? d[n-1] : 0;
            if (rd + int'(rnd) >= 10) begin
               k = 0;
               while (k < 32 && e[k] == 9) begin e[k] = 0; k++; end
               if (k < 32) e[k] = e[k] + 1;
            end
         end
         allz = 1'b1;
         for (int i = 0; i < nd; i++) if (e[i] != 0) allz = 1'b0;
         if (sh != 6'd0) begin
            for (int i = 0; i < nd; i++) r[4*i+4 +: 4] = 4'(e[i]);
            r[3:0] = (neg && !allz) ? 4'hD : 4'hC;
         end
         c = ov ? 2'd3 : allz ? 2'd0 : neg ? 2'd1 : 2'd2;
      end
   endtask

   // drive at a falling edge, return at the falling edge where the result is due
   task automatic apply(input logic [W-1:0] opd, input int len, input logic [5:0] sh, input logic [3:0] rnd);
      opd_i   = opd;
      len_i   = LW'(len);
      shamt_i = sh;
      rnd_i   = rnd;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      opd_i   = {W/32{32'hA5A5F00F}};
      shamt_i = 6'h15;
      repeat (LAT-1) @(negedge clk);
      chk("R11", "done", W'(done_o), W'(1));
   endtask

   task automatic run_model(input string tag, input logic [W-1:0] opd, input int len,
                            input logic [5:0] sh, input logic [3:0] rnd);
      logic [W-1:0] er;
      logic [1:0]   ec;
      logic         eb;
      model(opd, len, sh, rnd, er, ec, eb);
      apply(opd, len, sh, rnd);
      chk(tag, "result", result_o, er);
      chk(eb ? "R10" : (ec == 2'd3 ? "R3" : "R7"), "cc", W'(cc_o), W'(ec));
      chk("R10", "bad", W'(bad_o), W'(eb));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [W-1:0] opd;
      logic [W-1:0] keep;
      int unsigned  seed;
      seed = $urandom(32'd4711);
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12", "done", W'(done_o), W'(0));
      chk("R12", "result", result_o, W'(0));
      chk("R12", "cc", W'(cc_o), W'(0));
      chk("R12", "bad", W'(bad_o), W'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // R2 five-byte field, left by 4
      apply(W'(40'h000019654C), 4, 6'd4, 4'd0);
      chk("R2", "result", result_o, W'(40'h196540000C));
      chk("R7", "cc", W'(cc_o), W'(2));
      // R11 pulse lasts one cycle and outputs hold
      keep = result_o;
      repeat (3) begin
         @(negedge clk);
         chk("R11", "done low", W'(done_o), W'(0));
         chk("R11", "held", result_o, keep);
      end
      // R5 right by 2 with rounding 5
      apply(W'(40'h000019654C), 4, 6'd62, 4'd5);
      chk("R5", "result", result_o, W'(40'h000000197C));
      // R5 R4 negative, right by 3, rounding 5
      apply(W'(32'h7853975D), 3, 6'd61, 4'd5);
      chk("R5", "result", result_o, W'(32'h0007854D));
      chk("R7", "cc neg", W'(cc_o), W'(1));
      // R3 overflow in a one-byte field
      apply(W'(8'h5D), 0, 6'd1, 4'd0);
      chk("R3", "result", result_o, W'(8'h0C));
      chk("R3", "cc", W'(cc_o), W'(3));
      // R4 right by 32 clears a full field
      opd = {W/4{4'h9}};
      opd[3:0] = 4'hD;
      apply(opd, 15, 6'd32, 4'd9);
      chk("R4", "result", result_o, W'(4'hC));
      chk("R6", "cc zero", W'(cc_o), W'(0));
      // R8 zero count keeps the B sign
      apply(W'(24'h12345B), 2, 6'd0, 4'd9);
      chk("R8", "result", result_o, W'(24'h12345B));
      chk("R8", "cc", W'(cc_o), W'(1));
      // R10 illegal digit
      apply(W'(24'h1A345C), 2, 6'd2, 4'd0);
      chk("R10", "result", result_o, W'(24'h1A345C));
      chk("R10", "bad", W'(bad_o), W'(1));
      chk("R10", "cc", W'(cc_o), W'(0));
      // R9 upper bytes preserved, R1 left by 31
      run_model("R9", {{(W-16){1'b1}}, 16'h001C}, 1, 6'd31, 4'd0);
      run_model("R1", {{(W-8){1'b0}}, 8'h1C} | (W'(1) << 124), 15, 6'd31, 4'd0);
      // R5 rounding ignored on left moves, rounding 15 on right
      run_model("R5", W'(32'h0012345C), 3, 6'd2, 4'd9);
      run_model("R5", W'(32'h9999999C), 3, 6'd63, 4'd15);

      for (int t = 0; t < 400; t++) begin
         int len, nd, sig;
         logic [5:0] sh;
         for (int k = 0; k < W/32; k++) opd[32*k +: 32] = $urandom;
         len = int'($urandom % MB);
         nd  = 2*len + 1;
         sig = int'($urandom % (nd + 1));
         for (int i = 0; i < nd; i++)
            opd[4*i+4 +: 4] = (i < sig) ? 4'($urandom % 10) : 4'h0;
         opd[3:0] = 4'hA + 4'($urandom % 6);
         if ($urandom % 20 == 0) begin
            if ($urandom % 2 == 0) opd[3:0] = 4'($urandom % 10);
            else opd[4*int'($urandom % nd)+4 +: 4] = 4'hA + 4'($urandom % 6);
         end
         sh = 6'($urandom);
         run_model(sh == 6'd0 ? "R8" : (sh < 6'd32 ? "R2" : "R4"), opd, len, sh, 4'($urandom));
      end

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule